// File: doc/BRIEF.md
# Zero-Skipping Coefficient Scanner for Context-Adaptive Variable-Length Coding

This block sits in front of the table coders of a context-adaptive variable-length entropy encoder. It accepts one 4x4 block of signed quantized coefficients at a time, reorders them from raster order into zigzag order and marks which positions hold nonzero values. From that it derives the quantities the table coders need for the block: how many coefficients are nonzero, how many trailing ±1 values there are and their signs, how many zeros lie below the highest-frequency nonzero value, and, for each nonzero coefficient, its level and the run of zeros that separates it from the next lower-frequency nonzero value.

Output is a stream of records under a valid/ready handshake. Each block produces one header record followed by one record per nonzero coefficient, issued from the highest zigzag position downward. A leading-one detector over the remaining nonzero mask jumps directly from one nonzero coefficient to the next, so zero coefficients consume no cycles. An all-zero block therefore costs a single cycle, and a typical sparse block costs little more than its nonzero count. A second block can be loaded into a holding stage while the current one is still being emitted, so consecutive blocks stream without a gap.

Top module: `cavlcScanTop`

## Requirements
- R1: During and right after reset, `outValid` is 0 and `inReady` is 1.
- R2: Zigzag position k (0 = lowest frequency) takes the coefficient at raster index 0,1,4,8,5,2,3,6,9,12,13,10,7,11,14,15 for k = 0..15. Raster index is 4*row+col, and it occupies bits [16*index +: 16] of `blkIn`. Each coefficient record reports that zigzag position on `outPos` and the coefficient value on `outLevel`.
- R3: The header record (`outIsCoef` = 0) reports on `outTotalCoeff` the number of nonzero coefficients in the block.
- R4: After the header, one coefficient record (`outIsCoef` = 1) is issued per nonzero coefficient, in strictly descending zigzag position. With `outReady` held high, a block with n nonzero coefficients occupies exactly n+1 consecutive output cycles, whatever the positions of its zeros.
- R5: `outTrailOnes` counts, up to 3, the consecutive nonzero coefficients of magnitude 1 met first from the highest-frequency end. The count stops at the first nonzero coefficient of another magnitude. In `outTrailSigns`, bit i is 1 when the (i+1)-th trailing one is negative, and unused bits are 0.
- R6: `outTotalZeros` equals (highest nonzero zigzag position + 1) minus the nonzero count. It is 0 for an all-zero block.
- R7: On a coefficient record, `outRunBefore` is the number of zero positions between this coefficient and the next lower nonzero one, and 0 for the lowest. `outRunValid` is 1 only when a lower nonzero coefficient exists and zeros still remain to be accounted for, meaning total zeros minus the runs already issued for the block is nonzero.
- R8: An all-zero block produces a single header record with `outTotalCoeff` = 0 and `outLast` = 1, and it takes one output cycle.
- R9: While `outValid` is 1 and `outReady` is 0, every output field holds its value and `outValid` stays 1.
- R10: A block offered while the previous one is being emitted is accepted (`inReady` = 1 once the holding stage is free). Its header follows the previous block's final record in the very next cycle when `outReady` is high.
- R11: `outLast` is 1 exactly on the final record of a block, and the record after it is a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Load strobe; block taken when `inReady` is 1 |
| blkIn | input | 256 | Sixteen 16-bit signed coefficients, raster order |
| inReady | output | 1 | Holding stage can take a block |
| outValid | output | 1 | Output record present |
| outReady | input | 1 | Downstream accepts the record |
| outIsCoef | output | 1 | 0 = header record, 1 = coefficient record |
| outTotalCoeff | output | 5 | Nonzero count of the current block |
| outTrailOnes | output | 2 | Trailing ±1 count (0..3) |
| outTrailSigns | output | 3 | Trailing-one signs, bit0 = highest frequency |
| outTotalZeros | output | 4 | Zeros below the highest nonzero position |
| outLevel | output | 16 | Coefficient value (0 on header) |
| outRunBefore | output | 4 | Zero run below this coefficient |
| outRunValid | output | 1 | Run must be coded |
| outLast | output | 1 | Final record of the block |
| outPos | output | 4 | Zigzag position of the coefficient |

## Verification
The load of a new block into the holding stage and the issue of the current block's records happen in the same cycles. The most demanding case is the cycle in which the final record is taken while the waiting block moves into the emit stage. The bench provokes this by offering a second block as soon as `inReady` returns, while the first is still streaming. It judges the result by counting output cycles from the first header to the last record of the second block, which must equal the sum of both record counts with no idle cycle between them. The same overlap under a stalling consumer is covered by the back-pressure scenario, where every held record must remain unchanged.

// File: rtl/cavlcScanPkg.sv
package cavlcScanPkg;

  localparam int BLK_N = 16;
  localparam int POS_W = $clog2(BLK_N);
  localparam int CNT_W = POS_W + 1;

  // Per-block header quantities handed to the table coders.
  typedef struct packed {
    logic [CNT_W-1:0] totalCoeff;
    logic [1:0]       trailOnes;
    logic [2:0]       trailSigns;
    logic [POS_W-1:0] totalZeros;
  } blkHdrT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadPend;  // capture input block into holding stage
    logic moveAct;   // holding stage -> emit stage
    logic stepCoef;  // retire current nonzero coefficient
    logic showHdr;   // current record is the header
  } scanCtrlT;

  // Raster index feeding each zigzag position of a 4x4 block.
  function automatic int zzToRaster(input int k);
    case (k)
      0: return 0;   1: return 1;   2: return 4;   3: return 8;
      4: return 5;   5: return 2;   6: return 3;   7: return 6;
      8: return 9;   9: return 12; 10: return 13; 11: return 10;
      12: return 7; 13: return 11; 14: return 14; default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/scanDatapath.sv
module scanDatapath
  import cavlcScanPkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  scanCtrlT                ctrl,
  input  logic [BLK_N*COEF_W-1:0] blkIn,
  output logic                    hdrEmpty,
  output logic                    lastCoef,
  output blkHdrT                  outHdr,
  output logic [COEF_W-1:0]       outLevel,
  output logic [POS_W-1:0]        outRunBefore,
  output logic                    outRunValid,
  output logic [POS_W-1:0]        outPos
);

  // Highest set bit of a mask (0 when empty).
  function automatic logic [POS_W-1:0] topOne(input logic [BLK_N-1:0] m);
    logic [POS_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < BLK_N; i++) begin
      if (m[i]) idx = POS_W'(i);
    end
    return idx;
  endfunction

  // ---------------- zigzag reorder and nonzero mask ----------------
  logic [COEF_W-1:0] zzIn [BLK_N];
  logic [BLK_N-1:0]  inMask;

  generate
    for (genvar k = 0; k < BLK_N; k++) begin : gZz
      localparam int SRC = zzToRaster(k);
      assign zzIn[k]   = blkIn[SRC*COEF_W +: COEF_W];
      assign inMask[k] = |zzIn[k];
    end
  endgenerate

  // ---------------- block analysis on the incoming block ----------------
  logic [CNT_W-1:0] nzCount;
  logic [POS_W-1:0] nzTop;
  logic [CNT_W-1:0] zeroSpan;
  logic [1:0]       t1Count;
  logic [2:0]       t1Signs;
  logic             t1Stop;
  blkHdrT           inHdr;

  always_comb begin
    nzCount = '0;
    for (int i = 0; i < BLK_N; i++) nzCount = nzCount + CNT_W'(inMask[i]);
    nzTop    = topOne(inMask);
    zeroSpan = CNT_W'(nzTop) + CNT_W'(1) - nzCount;
  end

  always_comb begin
    t1Count = '0;
    t1Signs = '0;
    t1Stop  = 1'b0;
    for (int i = BLK_N - 1; i >= 0; i--) begin
      if (inMask[i] && !t1Stop) begin
        if (((zzIn[i] == COEF_W'(1)) || (zzIn[i] == {COEF_W{1'b1}})) && (t1Count != 2'd3)) begin
          t1Signs[t1Count] = zzIn[i][COEF_W-1];
          t1Count          = t1Count + 2'd1;
        end else begin
          t1Stop = 1'b1;
        end
      end
    end
  end

  always_comb begin
    inHdr.totalCoeff = nzCount;
    inHdr.trailOnes  = t1Count;
    inHdr.trailSigns = t1Signs;
    inHdr.totalZeros = (nzCount == '0) ? '0 : zeroSpan[POS_W-1:0];
  end

  // ---------------- holding stage ----------------
  logic [COEF_W-1:0] pendCoef [BLK_N];
  logic [BLK_N-1:0]  pendMask;
  blkHdrT            pendHdr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
      pendHdr  <= '0;
    end else if (ctrl.loadPend) begin
      pendMask <= inMask;
      pendHdr  <= inHdr;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.loadPend) begin
      for (int k = 0; k < BLK_N; k++) pendCoef[k] <= zzIn[k];
    end
  end

  // ---------------- emit stage with leading-one stepping ----------------
  logic [COEF_W-1:0] actCoef [BLK_N];
  logic [BLK_N-1:0]  remMask;
  blkHdrT            actHdr;
  logic [POS_W-1:0]  zerosLeft;

  logic [POS_W-1:0]  curPos;
  logic [POS_W-1:0]  nextPos;
  logic [BLK_N-1:0]  restMask;
  logic              hasNext;
  logic [POS_W-1:0]  runGap;

  assign curPos   = topOne(remMask);
  assign restMask = remMask & ~(BLK_N'(1) << curPos);
  assign nextPos  = topOne(restMask);
  assign hasNext  = |restMask;
  assign runGap   = hasNext ? (curPos - nextPos - POS_W'(1)) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remMask   <= '0;
      actHdr    <= '0;
      zerosLeft <= '0;
    end else if (ctrl.moveAct) begin
      remMask   <= pendMask;
      actHdr    <= pendHdr;
      zerosLeft <= pendHdr.totalZeros;
    end else if (ctrl.stepCoef) begin
      remMask   <= restMask;
      zerosLeft <= zerosLeft - runGap;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.moveAct) begin
      for (int k = 0; k < BLK_N; k++) actCoef[k] <= pendCoef[k];
    end
  end

  // ---------------- record fields ----------------
  assign hdrEmpty     = (actHdr.totalCoeff == '0);
  assign lastCoef     = !hasNext;
  assign outHdr       = actHdr;
  assign outLevel     = ctrl.showHdr ? '0 : actCoef[curPos];
  assign outRunBefore = ctrl.showHdr ? '0 : runGap;
  assign outRunValid  = !ctrl.showHdr && hasNext && (zerosLeft != '0);
  assign outPos       = ctrl.showHdr ? '0 : curPos;

endmodule

// File: rtl/scanControl.sv
module scanControl
  import cavlcScanPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startIn,
  input  logic     outReady,
  input  logic     hdrEmpty,
  input  logic     lastCoef,
  output scanCtrlT ctrl,
  output logic     inReady,
  output logic     outValid,
  output logic     outIsCoef,
  output logic     outLast
);

  logic pendFull;
  logic actFull;
  logic hdrPhase;
  logic fire;
  logic finish;

  assign fire     = actFull && outReady;
  assign outLast  = hdrPhase ? hdrEmpty : lastCoef;
  assign finish   = fire && outLast;

  assign ctrl.loadPend = startIn && !pendFull;
  assign ctrl.moveAct  = pendFull && (!actFull || finish);
  assign ctrl.stepCoef = fire && !hdrPhase;
  assign ctrl.showHdr  = hdrPhase;

  assign inReady   = !pendFull;
  assign outValid  = actFull;
  assign outIsCoef = !hdrPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendFull <= 1'b0;
      actFull  <= 1'b0;
      hdrPhase <= 1'b1;
    end else begin
      if (ctrl.loadPend)     pendFull <= 1'b1;
      else if (ctrl.moveAct) pendFull <= 1'b0;

      if (ctrl.moveAct)  actFull <= 1'b1;
      else if (finish)   actFull <= 1'b0;

      if (ctrl.moveAct)          hdrPhase <= 1'b1;
      else if (fire && hdrPhase) hdrPhase <= 1'b0;
    end
  end

endmodule

// File: rtl/cavlcScanTop.sv
module cavlcScanTop
  import cavlcScanPkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startIn,
  input  logic [BLK_N*COEF_W-1:0] blkIn,
  output logic                    inReady,
  output logic                    outValid,
  input  logic                    outReady,
  output logic                    outIsCoef,
  output logic [CNT_W-1:0]        outTotalCoeff,
  output logic [1:0]              outTrailOnes,
  output logic [2:0]              outTrailSigns,
  output logic [POS_W-1:0]        outTotalZeros,
  output logic [COEF_W-1:0]       outLevel,
  output logic [POS_W-1:0]        outRunBefore,
  output logic                    outRunValid,
  output logic                    outLast,
  output logic [POS_W-1:0]        outPos
);

  scanCtrlT ctrl;
  blkHdrT   hdr;
  logic     hdrEmpty;
  logic     lastCoef;

  scanControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .outReady  (outReady),
    .hdrEmpty  (hdrEmpty),
    .lastCoef  (lastCoef),
    .ctrl      (ctrl),
    .inReady   (inReady),
    .outValid  (outValid),
    .outIsCoef (outIsCoef),
    .outLast   (outLast)
  );

  scanDatapath #(.COEF_W(COEF_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .blkIn        (blkIn),
    .hdrEmpty     (hdrEmpty),
    .lastCoef     (lastCoef),
    .outHdr       (hdr),
    .outLevel     (outLevel),
    .outRunBefore (outRunBefore),
    .outRunValid  (outRunValid),
    .outPos       (outPos)
  );

  assign outTotalCoeff = hdr.totalCoeff;
  assign outTrailOnes  = hdr.trailOnes;
  assign outTrailSigns = hdr.trailSigns;
  assign outTotalZeros = hdr.totalZeros;

endmodule

// File: rtl/cavlcScanChecker.sv
module cavlcScanChecker
  import cavlcScanPkg::*;
#(
  parameter int COEF_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              outValid,
  input logic              outReady,
  input logic              outIsCoef,
  input logic [CNT_W-1:0]  outTotalCoeff,
  input logic [1:0]        outTrailOnes,
  input logic [2:0]        outTrailSigns,
  input logic [POS_W-1:0]  outTotalZeros,
  input logic [COEF_W-1:0] outLevel,
  input logic              outRunValid,
  input logic              outLast,
  input logic [POS_W-1:0]  outPos
);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outLevel) && $stable(outPos) && $stable(outIsCoef) && $stable(outLast));

  assert_descending_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outIsCoef && !outLast |=> outValid && outIsCoef && (outPos < $past(outPos)));

  assert_no_gap_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !outLast |=> outValid);

  assert_empty_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outIsCoef && (outTotalCoeff == '0) |-> outLast);

  assert_last_no_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outIsCoef && outLast |-> !outRunValid);

  assert_header_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outValid || !outIsCoef);

  assert_zero_budget_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((CNT_W + 1)'(outTotalCoeff) + (CNT_W + 1)'(outTotalZeros)) <= (CNT_W + 1)'(BLK_N));

  assert_trail_fields_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (CNT_W'(outTrailOnes) <= outTotalCoeff) && ((outTrailSigns >> outTrailOnes) == 3'd0));

endmodule

bind cavlcScanTop cavlcScanChecker #(.COEF_W(COEF_W)) chk (.*);

// File: tb/cavlcScanTop_test.sv
module cavlcScanTop_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [255:0] blkIn = '0;
  logic         outReady = 1'b1;
  logic         inReady, outValid, outIsCoef, outRunValid, outLast;
  logic [4:0]   outTotalCoeff;
  logic [1:0]   outTrailOnes;
  logic [2:0]   outTrailSigns;
  logic [3:0]   outTotalZeros, outRunBefore, outPos;
  logic [15:0]  outLevel;

  int checks = 0;
  int errors = 0;
  logic [40:0] expQ[$];
  logic stallMode = 1'b0;
  int rdyCnt = 0;
  logic prevStall = 1'b0;
  logic [40:0] prevRec = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cavlcScanTop uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .blkIn(blkIn), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outIsCoef(outIsCoef),
    .outTotalCoeff(outTotalCoeff), .outTrailOnes(outTrailOnes), .outTrailSigns(outTrailSigns),
    .outTotalZeros(outTotalZeros), .outLevel(outLevel), .outRunBefore(outRunBefore),
    .outRunValid(outRunValid), .outLast(outLast), .outPos(outPos)
  );

  function automatic int zzSrc(input int k);
    int tbl[16] = '{0, 1, 4, 8, 5, 2, 3, 6, 9, 12, 13, 10, 7, 11, 14, 15};
    return tbl[k];
  endfunction

  task automatic chk(input int a, input int e, input string tag);
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  // Expected record stream for one block, built from the requirements.
  task automatic pushModel(input logic [255:0] b);
    logic signed [15:0] z[16];
    int tc, top, tz, t1, zl, nxt, rb, stop;
    logic [2:0] sg;
    for (int k = 0; k < 16; k++) z[k] = b[zzSrc(k)*16 +: 16];
    tc = 0; top = -1;
    for (int k = 0; k < 16; k++) if (z[k] != 0) begin tc++; top = k; end
    tz = (tc == 0) ? 0 : top + 1 - tc;
    t1 = 0; sg = '0; stop = 0;
    for (int k = 15; k >= 0; k--) begin
      if (z[k] != 0 && stop == 0) begin
        if ((z[k] == 1 || z[k] == -1) && t1 < 3) begin
          sg[t1] = (z[k] < 0);
          t1++;
        end else stop = 1;
      end
    end
    expQ.push_back({1'b0, 5'(tc), 2'(t1), sg, 4'(tz), 16'd0, 4'd0, 1'b0, (tc == 0), 4'd0});
    zl = tz;
    for (int k = 15; k >= 0; k--) begin
      if (z[k] != 0) begin
        nxt = -1;
        for (int j = k - 1; j >= 0; j--) if (z[j] != 0 && nxt < 0) nxt = j;
        rb = (nxt >= 0) ? k - nxt - 1 : 0;
        expQ.push_back({1'b1, 5'(tc), 2'(t1), sg, 4'(tz), z[k], 4'(rb),
                        ((nxt >= 0) && (zl != 0)), (nxt < 0), 4'(k)});
        zl -= rb;
      end
    end
  endtask

  // Monitor: compares every accepted record, and held records under stall.
  always @(negedge clk) begin
    logic [40:0] act, exp;
    if (rstN) begin
      act = {outIsCoef, outTotalCoeff, outTrailOnes, outTrailSigns, outTotalZeros,
             outLevel, outRunBefore, outRunValid, outLast, outPos};
      if (prevStall) begin
        chk(int'(outValid), 1, "R9 valid held under stall");
        chk(int'(act == prevRec), 1, "R9 record held under stall");
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) chk(1, 0, "R4 unexpected record");
        else begin
          exp = expQ.pop_front();
          chk(int'(act[40]), int'(exp[40]), "R4 record kind");
          chk(int'(act[39:35]), int'(exp[39:35]), "R3 total coeff");
          chk(int'(act[34:33]), int'(exp[34:33]), "R5 trailing ones");
          chk(int'(act[32:30]), int'(exp[32:30]), "R5 trailing signs");
          chk(int'(act[29:26]), int'(exp[29:26]), "R6 total zeros");
          chk(int'(act[25:10]), int'(exp[25:10]), "R2 level");
          chk(int'(act[9:6]), int'(exp[9:6]), "R7 run before");
          chk(int'(act[5]), int'(exp[5]), "R7 run valid");
          chk(int'(act[4]), int'(exp[4]), "R11 last flag");
          chk(int'(act[3:0]), int'(exp[3:0]), "R2 zigzag position");
        end
      end
      prevStall = outValid && !outReady;
      prevRec   = act;
    end
  end

  always @(posedge clk) begin
    #1;
    rdyCnt++;
    outReady = !stallMode || (rdyCnt % 3 == 0);
  end

  task automatic loadBlk(input logic [255:0] b);
    while (!inReady) begin @(posedge clk); #1; end
    pushModel(b);
    blkIn = b;
    startIn = 1'b1;
    @(posedge clk); #1;
    startIn = 1'b0;
  endtask

  task automatic countSpan(output int span);
    int guard = 0;
    span = 0;
    do begin @(negedge clk); #1; guard++; end while (!outValid && guard < 100);
    span = 1;
    while (expQ.size() != 0 && guard < 300) begin
      @(negedge clk); #1; guard++; span++;
    end
  endtask

  task automatic drain();
    int guard = 0;
    while ((expQ.size() != 0 || outValid) && guard < 500) begin @(posedge clk); #1; guard++; end
    chk(expQ.size(), 0, "R4 all expected records issued");
  endtask

  task automatic runOne(input logic [255:0] b, input int expSpan, input string tag);
    int span;
    loadBlk(b);
    countSpan(span);
    chk(span, expSpan, tag);
    drain();
  endtask

  task automatic tReset();
    @(negedge clk);
    chk(int'(outValid), 0, "R1 valid low in reset");
    chk(int'(inReady), 1, "R1 ready high in reset");
    rstN = 1'b1;
    @(negedge clk);
    chk(int'(outValid), 0, "R1 valid low after reset");
    chk(int'(inReady), 1, "R1 ready high after reset");
    @(posedge clk); #1;
  endtask

  task automatic tDcOnly();
    logic [255:0] b = '0;
    b[0 +: 16] = 16'sd5;
    runOne(b, 2, "R3 single dc block span");
  endtask

  task automatic tEmpty();
    runOne('0, 1, "R8 empty block one cycle");
  endtask

  task automatic tTrailFour();
    logic [255:0] b = '0;
    b[0*16 +: 16] = 16'sd1;
    b[1*16 +: 16] = -16'sd1;
    b[4*16 +: 16] = 16'sd1;
    b[8*16 +: 16] = -16'sd1;
    b[3*16 +: 16] = -16'sd1;
    runOne(b, 6, "R5 four unit values span");
  endtask

  task automatic tStopAtBig();
    logic [255:0] b = '0;
    b[15*16 +: 16] = -16'sd1;
    b[14*16 +: 16] = 16'sd7;
    b[11*16 +: 16] = 16'sd1;
    b[0*16 +: 16]  = -16'sd300;
    runOne(b, 5, "R5 trailing ones stop at larger level");
  endtask

  task automatic tRunsSuppressed();
    logic [255:0] b = '0;
    b[2*16 +: 16] = 16'sd4;
    b[8*16 +: 16] = -16'sd2;
    b[1*16 +: 16] = 16'sd9;
    b[0*16 +: 16] = 16'sd3;
    runOne(b, 5, "R7 run suppression block span");
  endtask

  task automatic tRunsLong();
    logic [255:0] b = '0;
    b[12*16 +: 16] = 16'sd2;
    b[9*16 +: 16]  = 16'sd2;
    b[8*16 +: 16]  = -16'sd5;
    b[0*16 +: 16]  = 16'sd11;
    runOne(b, 5, "R6 long runs block span");
  endtask

  task automatic tDense();
    logic [255:0] b = '0;
    for (int i = 0; i < 16; i++) b[i*16 +: 16] = 16'(i + 2);
    runOne(b, 17, "R4 dense block span");
  endtask

  task automatic tSparse();
    logic [255:0] b = '0;
    b[15*16 +: 16] = -16'sd9;
    b[0*16 +: 16]  = 16'sd4;
    runOne(b, 3, "R4 zeros cost no cycles");
  endtask

  task automatic tStall();
    logic [255:0] b = '0;
    b[5*16 +: 16]  = 16'sd1;
    b[7*16 +: 16]  = -16'sd3;
    b[13*16 +: 16] = 16'sd1;
    b[10*16 +: 16] = 16'sd6;
    stallMode = 1'b1;
    loadBlk(b);
    loadBlk('0);
    drain();
    stallMode = 1'b0;
    @(posedge clk); #1;
    chk(int'(outReady), 1, "R9 consumer released");
  endtask

  task automatic tOverlap();
    logic [255:0] a = '0;
    logic [255:0] b = '0;
    int span;
    a[6*16 +: 16]  = 16'sd2;
    a[9*16 +: 16]  = -16'sd1;
    a[0*16 +: 16]  = 16'sd8;
    b[15*16 +: 16] = 16'sd1;
    b[2*16 +: 16]  = -16'sd4;
    fork
      countSpan(span);
      begin loadBlk(a); loadBlk(b); end
    join
    chk(span, 4 + 3, "R10 back-to-back blocks without gap");
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    tReset();
    tDcOnly();
    tEmpty();
    tTrailFour();
    tStopAtBig();
    tRunsSuppressed();
    tRunsLong();
    tDense();
    tSparse();
    tStall();
    tOverlap();
    tEmpty();
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule